// File: doc/BRIEF.md
# Multi-Anode Pixel Frame Processor

This block takes one frame of digitised samples from an 8x8 multi-anode photodetector, one sample per accepted input beat, and turns it into a compact result stream. In acquisition modes it estimates a common-mode offset over the whole frame and removes it from every pixel. It then subtracts a scaled share of each pixel's orthogonal neighbours to undo charge leakage, compares the result against a programmable threshold, and emits either a hit list, a hit bitmap or a 2-bit amplitude code per pixel. A calibration mode forwards every raw sample untouched so that the correction chain can be checked offline.

Frames are double-buffered. A capture bank fills while the previous frame is corrected and emitted from a processing bank. Configuration is sampled with the first sample of a frame and travels with that frame. A frame whose end marker does not fall on exactly the 64th sample is discarded and reported with a one-cycle pulse. The output uses a valid/ready handshake, and downstream back-pressure simply stalls the emitter.

Top module: `pfp_frame_proc`

## Requirements
- R1: A frame begins with a sample carrying `in_sof`. Pixel index p = row*8 + column is the order of arrival (sample 0 is p=0). Samples that arrive outside a started frame are ignored.
- R2: If `in_eof` comes with any sample other than the 64th of the frame (early or late), the frame produces no output and `frame_drop` pulses high for one cycle, in the cycle after that sample.
- R3: `cfg_*` values are captured with the `in_sof` sample. Changing them later in the frame does not affect that frame.
- R4: The offset is the floor of the mean of the samples strictly below `cfg_ped_win`. It is 0 when no sample qualifies, when `cfg_ped_bypass` is 1, or in mode 3.
- R5: The offset-corrected value of a pixel is its sample minus the offset, saturated at 0.
- R6: The final value of a pixel is its corrected value minus (sum of the corrected values of its existing up/down/left/right neighbours) >> `cfg_xt_shift`, saturated at 0. A pixel is a hit when the final value is strictly greater than `cfg_thresh`.
- R7: Mode 0: one word per hit pixel, in ascending index, with bits [13:8] = index, bits [7:0] = final value, and all other bits 0. This is followed by a trailer word with `out_last`=1, bit 63 = 1, bits [6:0] = number of hits, and other bits 0.
- R8: Mode 1: a single word with `out_last`=1, where bit p = 1 exactly when pixel p is a hit.
- R9: Mode 2: two words, the second with `out_last`=1. Word w holds pixel p = 32w+k in bits [2k+1:2k]. The code is 3 if value > 4*thresh, else 2 if > 2*thresh, else 1 if > thresh, else 0.
- R10: Mode 3: 64 words in pixel order, each with bits [7:0] = raw sample and all other bits 0. `out_last` is 1 only on the 64th word.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R12: After reset `in_ready` is 1. It goes low only after a complete frame has been captured while the previous frame is still being processed. A second frame can therefore be captured without stalling while the first is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample valid |
| in_data | input | 8 | Unsigned pixel sample |
| in_sof | input | 1 | First sample of a frame |
| in_eof | input | 1 | Last sample of a frame |
| in_ready | output | 1 | Block accepts a sample |
| cfg_mode | input | 2 | 0 hit list, 1 hit map, 2 code, 3 raw |
| cfg_thresh | input | 8 | Discrimination threshold |
| cfg_ped_win | input | 8 | Offset estimation window (exclusive upper limit) |
| cfg_ped_bypass | input | 1 | Force offset to zero |
| cfg_xt_shift | input | 3 | Neighbour sum right shift |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Downstream accepts result |
| out_data | output | 64 | Result word |
| out_last | output | 1 | Last word of a frame's result |
| frame_drop | output | 1 | One-cycle pulse for a discarded frame |

## Verification
A wrong offset or a mis-wired neighbour term corrupts the final value of many pixels at once. It shows up in the first hit word, map word or code word the frame produces, which is at most a few cycles after that frame's 80-cycle correction phase. A capture counter that is off by one either drops a good frame, which shows immediately as a missing `out_last` and an extra `frame_drop`, or shifts every pixel index. The shift shows in the first list entry. Mixing up the banks or snapshotting configuration late shows as the wrong frame's data or format in the next result. Random back-pressure on `out_ready` makes every hold and advance path of the emitter visible.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    typedef enum logic [1:0] {
        MODE_LIST = 2'd0,
        MODE_MAP  = 2'd1,
        MODE_CODE = 2'd2,
        MODE_RAW  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_SCAN = 2'd1,
        PS_DIV  = 2'd2
    } ped_state_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PED  = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;

    typedef struct packed {
        mode_e      mode;
        logic       bypass;
        logic [2:0] shift;
    } ctl_t;

endpackage

// File: rtl/pfp_capture.sv
module pfp_capture
    import pfp_pkg::*;
#(
    parameter int NPIX = 64,
    parameter int SW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [SW-1:0]        in_data,
    input  logic                 in_sof,
    input  logic                 in_eof,
    output logic                 in_ready,
    input  ctl_t                 cfg_ctl,
    input  logic [SW-1:0]        cfg_thr,
    input  logic [SW-1:0]        cfg_win,
    input  logic                 take,
    output logic                 full,
    output logic                 drop,
    output logic [NPIX*SW-1:0]   bank_flat,
    output ctl_t                 snap_ctl,
    output logic [SW-1:0]        snap_thr,
    output logic [SW-1:0]        snap_win
);
    localparam int IDXW = $clog2(NPIX);
    localparam int CNTW = IDXW + 1;

    typedef struct packed {
        logic [NPIX-1:0][SW-1:0] bank;
        logic [CNTW-1:0]         cnt;
        logic                    active;
        logic                    full;
        logic                    drop;
        ctl_t                    ctl;
        logic [SW-1:0]           thr;
        logic [SW-1:0]           win;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.drop = 1'b0;
        if (take) begin
            cap_d.full = 1'b0;
        end
        if (in_valid && !cap_q.full) begin
            if (in_sof) begin
                cap_d.active  = !in_eof;
                cap_d.drop    = in_eof;
                cap_d.cnt     = CNTW'(1);
                cap_d.bank[0] = in_data;
                cap_d.ctl     = cfg_ctl;
                cap_d.thr     = cfg_thr;
                cap_d.win     = cfg_win;
            end else if (cap_q.active) begin
                if (cap_q.cnt < CNTW'(NPIX)) begin
                    cap_d.bank[cap_q.cnt[IDXW-1:0]] = in_data;
                    cap_d.cnt = cap_q.cnt + CNTW'(1);
                end
                if (in_eof) begin
                    cap_d.active = 1'b0;
                    if (cap_q.cnt == CNTW'(NPIX - 1)) begin
                        cap_d.full = 1'b1;
                    end else begin
                        cap_d.drop = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign in_ready  = !cap_q.full;
    assign full      = cap_q.full;
    assign drop      = cap_q.drop;
    assign bank_flat = cap_q.bank;
    assign snap_ctl  = cap_q.ctl;
    assign snap_thr  = cap_q.thr;
    assign snap_win  = cap_q.win;

endmodule

// File: rtl/pfp_pedestal.sv
module pfp_pedestal
    import pfp_pkg::*;
#(
    parameter int NPIX = 64,
    parameter int SW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               bypass,
    input  logic [SW-1:0]      win,
    input  logic [NPIX*SW-1:0] bank_flat,
    output logic               done,
    output logic [SW-1:0]      ped
);
    localparam int IDXW = $clog2(NPIX);
    localparam int CNTW = IDXW + 1;
    localparam int SUMW = SW + IDXW;
    localparam int BW   = $clog2(SUMW);

    typedef struct packed {
        ped_state_e      st;
        logic [IDXW-1:0] idx;
        logic [SUMW-1:0] sum;
        logic [CNTW-1:0] cnt;
        logic [CNTW:0]   rem;
        logic [SUMW-1:0] quo;
        logic [BW-1:0]   bitn;
        logic            done;
        logic [SW-1:0]   ped;
    } ped_t;

    ped_t ped_d, ped_q;
    logic [SW-1:0] sample;
    logic [CNTW:0] trial;

    assign sample = bank_flat[int'(ped_q.idx) * SW +: SW];
    assign trial  = {ped_q.rem[CNTW-1:0], ped_q.sum[ped_q.bitn]};

    always_comb begin
        ped_d      = ped_q;
        ped_d.done = 1'b0;
        unique case (ped_q.st)
            PS_IDLE: begin
                if (start) begin
                    ped_d.st  = PS_SCAN;
                    ped_d.idx = '0;
                    ped_d.sum = '0;
                    ped_d.cnt = '0;
                end
            end
            PS_SCAN: begin
                if (bypass) begin
                    ped_d.ped  = '0;
                    ped_d.done = 1'b1;
                    ped_d.st   = PS_IDLE;
                end else begin
                    if (sample < win) begin
                        ped_d.sum = ped_q.sum + SUMW'(sample);
                        ped_d.cnt = ped_q.cnt + CNTW'(1);
                    end
                    ped_d.idx = ped_q.idx + IDXW'(1);
                    if (ped_q.idx == IDXW'(NPIX - 1)) begin
                        ped_d.st   = PS_DIV;
                        ped_d.rem  = '0;
                        ped_d.quo  = '0;
                        ped_d.bitn = BW'(SUMW - 1);
                    end
                end
            end
            PS_DIV: begin
                if (ped_q.cnt == '0) begin
                    ped_d.ped  = '0;
                    ped_d.done = 1'b1;
                    ped_d.st   = PS_IDLE;
                end else begin
                    if (trial >= {1'b0, ped_q.cnt}) begin
                        ped_d.rem = trial - {1'b0, ped_q.cnt};
                        ped_d.quo[ped_q.bitn] = 1'b1;
                    end else begin
                        ped_d.rem = trial;
                    end
                    if (ped_q.bitn == '0) begin
                        ped_d.ped  = ped_d.quo[SW-1:0];
                        ped_d.done = 1'b1;
                        ped_d.st   = PS_IDLE;
                    end else begin
                        ped_d.bitn = ped_q.bitn - BW'(1);
                    end
                end
            end
            default: ped_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ped_q <= '0;
        end else begin
            ped_q <= ped_d;
        end
    end

    assign done = ped_q.done;
    assign ped  = ped_q.ped;

endmodule

// File: rtl/pfp_pixel_array.sv
module pfp_pixel_array #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int SW   = 8
) (
    input  logic [ROWS*COLS*SW-1:0] bank_flat,
    input  logic [SW-1:0]           ped,
    input  logic [2:0]              shift,
    input  logic [SW-1:0]           thr,
    output logic [ROWS*COLS*SW-1:0] val_flat,
    output logic [ROWS*COLS-1:0]    hit,
    output logic [2*ROWS*COLS-1:0]  code_flat
);
    localparam int NPIX = ROWS * COLS;
    localparam int XW   = SW + 2;

    logic [SW-1:0] cv [NPIX];
    logic [XW-1:0] t1, t2, t4;

    assign t1 = {2'b00, thr};
    assign t2 = {1'b0, thr, 1'b0};
    assign t4 = {thr, 2'b00};

    for (genvar p = 0; p < NPIX; p++) begin : g_cm
        logic [SW-1:0] raw;
        assign raw   = bank_flat[p*SW +: SW];
        assign cv[p] = (raw > ped) ? raw - ped : '0;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int P = r * COLS + c;
            logic [XW-1:0] tu, tdn, tl, tr, nsum, xt, own, fin;

            if (r > 0) begin : g_u
                assign tu = {2'b00, cv[P-COLS]};
            end else begin : g_nu
                assign tu = '0;
            end
            if (r < ROWS - 1) begin : g_d
                assign tdn = {2'b00, cv[P+COLS]};
            end else begin : g_nd
                assign tdn = '0;
            end
            if (c > 0) begin : g_l
                assign tl = {2'b00, cv[P-1]};
            end else begin : g_nl
                assign tl = '0;
            end
            if (c < COLS - 1) begin : g_r
                assign tr = {2'b00, cv[P+1]};
            end else begin : g_nr
                assign tr = '0;
            end

            assign nsum = tu + tdn + tl + tr;
            assign xt   = nsum >> shift;
            assign own  = {2'b00, cv[P]};
            assign fin  = (own > xt) ? own - xt : '0;

            assign val_flat[P*SW +: SW] = fin[SW-1:0];
            assign hit[P] = fin > t1;
            assign code_flat[2*P +: 2] = (fin > t4) ? 2'd3 :
                                         (fin > t2) ? 2'd2 :
                                         (fin > t1) ? 2'd1 : 2'd0;
        end
    end

endmodule

// File: rtl/pfp_emitter.sv
module pfp_emitter
    import pfp_pkg::*;
#(
    parameter int NPIX = 64,
    parameter int SW   = 8,
    parameter int OW   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  mode_e              mode,
    input  logic [NPIX*SW-1:0] raw_flat,
    input  logic [NPIX*SW-1:0] val_flat,
    input  logic [NPIX-1:0]    hit,
    input  logic [2*NPIX-1:0]  code_flat,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [OW-1:0]      out_data,
    output logic               out_last,
    output mode_e              out_mode,
    output logic               busy
);
    localparam int IDXW = $clog2(NPIX);
    localparam int CNTW = IDXW + 1;
    localparam int CW   = (2 * NPIX) / OW;
    localparam int WW   = (CW > 1) ? $clog2(CW) : 1;

    typedef struct packed {
        logic            run;
        mode_e           m;
        logic [CNTW-1:0] idx;
        logic [WW-1:0]   word;
        logic [CNTW-1:0] hits;
        logic            ov;
        logic [OW-1:0]   od;
        logic            ol;
        mode_e           om;
    } em_t;

    em_t em_d, em_q;
    logic can_load;
    logic [IDXW-1:0] pix;

    assign can_load = !em_q.ov || out_ready;
    assign pix      = em_q.idx[IDXW-1:0];

    always_comb begin
        em_d = em_q;
        if (em_q.ov && out_ready) begin
            em_d.ov = 1'b0;
        end
        if (!em_q.run) begin
            if (start) begin
                em_d.run  = 1'b1;
                em_d.m    = mode;
                em_d.idx  = '0;
                em_d.word = '0;
                em_d.hits = '0;
            end
        end else begin
            unique case (em_q.m)
                MODE_LIST: begin
                    if (em_q.idx == CNTW'(NPIX)) begin
                        if (can_load) begin
                            em_d.ov = 1'b1;
                            em_d.od = '0;
                            em_d.od[OW-1] = 1'b1;
                            em_d.od[CNTW-1:0] = em_q.hits;
                            em_d.ol  = 1'b1;
                            em_d.om  = em_q.m;
                            em_d.run = 1'b0;
                        end
                    end else if (!hit[pix]) begin
                        em_d.idx = em_q.idx + CNTW'(1);
                    end else if (can_load) begin
                        em_d.ov   = 1'b1;
                        em_d.od   = OW'({pix, val_flat[int'(pix) * SW +: SW]});
                        em_d.ol   = 1'b0;
                        em_d.om   = em_q.m;
                        em_d.hits = em_q.hits + CNTW'(1);
                        em_d.idx  = em_q.idx + CNTW'(1);
                    end
                end
                MODE_MAP: begin
                    if (can_load) begin
                        em_d.ov  = 1'b1;
                        em_d.od  = OW'(hit);
                        em_d.ol  = 1'b1;
                        em_d.om  = em_q.m;
                        em_d.run = 1'b0;
                    end
                end
                MODE_CODE: begin
                    if (can_load) begin
                        em_d.ov   = 1'b1;
                        em_d.od   = code_flat[int'(em_q.word) * OW +: OW];
                        em_d.ol   = (em_q.word == WW'(CW - 1));
                        em_d.om   = em_q.m;
                        em_d.word = em_q.word + WW'(1);
                        if (em_q.word == WW'(CW - 1)) begin
                            em_d.run = 1'b0;
                        end
                    end
                end
                MODE_RAW: begin
                    if (can_load) begin
                        em_d.ov  = 1'b1;
                        em_d.od  = OW'(raw_flat[int'(pix) * SW +: SW]);
                        em_d.ol  = (em_q.idx == CNTW'(NPIX - 1));
                        em_d.om  = em_q.m;
                        em_d.idx = em_q.idx + CNTW'(1);
                        if (em_q.idx == CNTW'(NPIX - 1)) begin
                            em_d.run = 1'b0;
                        end
                    end
                end
                default: em_d.run = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            em_q <= '0;
        end else begin
            em_q <= em_d;
        end
    end

    assign out_valid = em_q.ov;
    assign out_data  = em_q.od;
    assign out_last  = em_q.ol;
    assign out_mode  = em_q.om;
    assign busy      = em_q.run;

endmodule

// File: rtl/pfp_frame_proc.sv
module pfp_frame_proc
    import pfp_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int SW   = 8,
    parameter int OW   = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic          in_ready,
    input  logic [1:0]    cfg_mode,
    input  logic [SW-1:0] cfg_thresh,
    input  logic [SW-1:0] cfg_ped_win,
    input  logic          cfg_ped_bypass,
    input  logic [2:0]    cfg_xt_shift,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [OW-1:0] out_data,
    output logic          out_last,
    output logic          frame_drop
);
    localparam int NPIX = ROWS * COLS;

    typedef struct packed {
        phase_e                  phase;
        logic [NPIX-1:0][SW-1:0] bank;
        ctl_t                    ctl;
        logic [SW-1:0]           thr;
        logic [SW-1:0]           win;
    } top_t;

    top_t top_d, top_q;

    ctl_t                 cfg_ctl, snap_ctl;
    logic [SW-1:0]        snap_thr, snap_win, ped;
    logic [NPIX*SW-1:0]   cap_bank, val_flat;
    logic [NPIX-1:0]      hit;
    logic [2*NPIX-1:0]    code_flat;
    logic                 cap_full, take, ped_done, emit_busy;
    mode_e                emit_mode;

    assign cfg_ctl = '{mode: mode_e'(cfg_mode), bypass: cfg_ped_bypass, shift: cfg_xt_shift};
    assign take    = (top_q.phase == PH_IDLE) && cap_full;

    pfp_capture #(.NPIX(NPIX), .SW(SW)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready),
        .cfg_ctl(cfg_ctl), .cfg_thr(cfg_thresh), .cfg_win(cfg_ped_win),
        .take(take), .full(cap_full), .drop(frame_drop),
        .bank_flat(cap_bank), .snap_ctl(snap_ctl), .snap_thr(snap_thr), .snap_win(snap_win)
    );

    always_comb begin
        top_d = top_q;
        unique case (top_q.phase)
            PH_IDLE: begin
                if (take) begin
                    top_d.bank  = cap_bank;
                    top_d.ctl   = snap_ctl;
                    top_d.thr   = snap_thr;
                    top_d.win   = snap_win;
                    top_d.phase = PH_PED;
                end
            end
            PH_PED:  if (ped_done)   top_d.phase = PH_EMIT;
            PH_EMIT: if (!emit_busy) top_d.phase = PH_IDLE;
            default: top_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    pfp_pedestal #(.NPIX(NPIX), .SW(SW)) u_ped (
        .clk(clk), .rst_n(rst_n), .start(take),
        .bypass(top_q.ctl.bypass || (top_q.ctl.mode == MODE_RAW)),
        .win(top_q.win), .bank_flat(top_q.bank),
        .done(ped_done), .ped(ped)
    );

    pfp_pixel_array #(.ROWS(ROWS), .COLS(COLS), .SW(SW)) u_pix (
        .bank_flat(top_q.bank), .ped(ped), .shift(top_q.ctl.shift), .thr(top_q.thr),
        .val_flat(val_flat), .hit(hit), .code_flat(code_flat)
    );

    pfp_emitter #(.NPIX(NPIX), .SW(SW), .OW(OW)) u_emit (
        .clk(clk), .rst_n(rst_n), .start(ped_done), .mode(top_q.ctl.mode),
        .raw_flat(top_q.bank), .val_flat(val_flat), .hit(hit), .code_flat(code_flat),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_mode(emit_mode), .busy(emit_busy)
    );

endmodule

// File: rtl/pfp_frame_proc_chk.sv
module pfp_frame_proc_chk
    import pfp_pkg::*;
#(
    parameter int SW  = 8,
    parameter int OW  = 64,
    parameter int IXW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_eof,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [OW-1:0] out_data,
    input logic          out_last,
    input logic          frame_drop,
    input mode_e         word_mode
);
    // R11: a stalled word is held
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R2: a drop pulse follows an accepted end marker
    p_drop_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |-> $past(in_valid && in_ready && in_eof));

    // R12: input stalls only once a frame has been completed
    p_stall_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid && in_eof));

    // R7: list word layout and trailer marker
    p_list_format_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && word_mode == MODE_LIST |->
            (out_last ? out_data[OW-1] : (out_data[OW-1:IXW+SW] == '0)));

    // R8: a map result is a single closing word
    p_map_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && word_mode == MODE_MAP |-> out_last);

    // R10: raw words carry only the sample
    p_raw_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && word_mode == MODE_RAW |-> out_data[OW-1:SW] == '0);

endmodule

bind pfp_frame_proc pfp_frame_proc_chk #(.SW(SW), .OW(OW), .IXW($clog2(ROWS*COLS))) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .frame_drop(frame_drop), .word_mode(emit_mode)
);

// File: tb/pfp_frame_proc_tb.sv
module pfp_frame_proc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready;
    logic [1:0] cfg_mode = '0;
    logic [7:0] cfg_thresh = '0, cfg_ped_win = '0;
    logic cfg_ped_bypass = 1'b0;
    logic [2:0] cfg_xt_shift = '0;
    logic out_valid, out_last, frame_drop;
    logic out_ready = 1'b0;
    logic [63:0] out_data;

    int errors = 0, checks = 0;
    int drops_exp = 0, drops_seen = 0, stall_cnt = 0;
    bit finished = 1'b0;
    logic [64:0] exp_q[$];
    string tag_q[$];
    logic [7:0] pix [NP];
    bit held = 1'b0;
    logic [64:0] held_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfp_frame_proc u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
        .cfg_mode(cfg_mode), .cfg_thresh(cfg_thresh), .cfg_ped_win(cfg_ped_win),
        .cfg_ped_bypass(cfg_ped_bypass), .cfg_xt_shift(cfg_xt_shift),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .frame_drop(frame_drop)
    );

    task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic void expect_frame(input int mode, input int thr, input int win,
                                         input bit byp, input int sh, input string tag);
        int ped, sum, cnt, nh;
        int c [NP];
        int v [NP];
        logic [63:0] w;
        ped = 0; sum = 0; cnt = 0;
        if (!byp && mode != 3) begin
            for (int p = 0; p < NP; p++) if (int'(pix[p]) < win) begin sum += pix[p]; cnt++; end
            if (cnt > 0) ped = sum / cnt;
        end
        for (int p = 0; p < NP; p++) c[p] = (int'(pix[p]) > ped) ? int'(pix[p]) - ped : 0;
        for (int p = 0; p < NP; p++) begin
            int n, x;
            n = 0;
            if (p / 8 > 0) n += c[p-8];
            if (p / 8 < 7) n += c[p+8];
            if (p % 8 > 0) n += c[p-1];
            if (p % 8 < 7) n += c[p+1];
            x = n >> sh;
            v[p] = (c[p] > x) ? c[p] - x : 0;
        end
        case (mode)
            0: begin
                nh = 0;
                for (int p = 0; p < NP; p++) if (v[p] > thr) begin
                    w = '0; w[13:8] = 6'(p); w[7:0] = 8'(v[p]);
                    exp_q.push_back({1'b0, w}); tag_q.push_back(tag); nh++;
                end
                w = '0; w[63] = 1'b1; w[6:0] = 7'(nh);
                exp_q.push_back({1'b1, w}); tag_q.push_back(tag);
            end
            1: begin
                w = '0;
                for (int p = 0; p < NP; p++) w[p] = (v[p] > thr);
                exp_q.push_back({1'b1, w}); tag_q.push_back(tag);
            end
            2: begin
                for (int wi = 0; wi < 2; wi++) begin
                    w = '0;
                    for (int k = 0; k < 32; k++) begin
                        int p, cd;
                        p = 32*wi + k;
                        cd = (v[p] > 4*thr) ? 3 : (v[p] > 2*thr) ? 2 : (v[p] > thr) ? 1 : 0;
                        w[2*k +: 2] = 2'(cd);
                    end
                    exp_q.push_back({(wi == 1), w}); tag_q.push_back(tag);
                end
            end
            default: begin
                for (int p = 0; p < NP; p++) begin
                    w = 64'(pix[p]);
                    exp_q.push_back({(p == NP-1), w}); tag_q.push_back(tag);
                end
            end
        endcase
    endfunction

    task automatic drive_sample(input logic [7:0] d, input bit sof, input bit eof);
        in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof;
        forever begin
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            stall_cnt++;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send_frame(input int mode, input int thr, input int win, input bit byp,
                              input int sh, input string tag, input bit mid_change);
        cfg_mode = 2'(mode); cfg_thresh = 8'(thr); cfg_ped_win = 8'(win);
        cfg_ped_bypass = byp; cfg_xt_shift = 3'(sh);
        expect_frame(mode, thr, win, byp, sh, tag);
        for (int i = 0; i < NP; i++) begin
            drive_sample(pix[i], i == 0, i == NP-1);
            if (mid_change && i == 0) begin
                cfg_mode = 2'd3; cfg_thresh = 8'd0; cfg_ped_win = 8'd255;
                cfg_ped_bypass = 1'b1; cfg_xt_shift = 3'd0;
            end
        end
    endtask

    task automatic send_bad(input int len);
        drops_exp++;
        for (int i = 0; i < len; i++) drive_sample(8'(i * 7), i == 0, i == len-1);
    endtask

    // monitor: choose ready, then compare words that will transfer at the next edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (held) begin
                    check(out_valid && {out_last, out_data} == held_word, "R11 hold",
                          {out_last, out_data}, held_word);
                    held = 1'b0;
                end
                out_ready = ($urandom % 4) != 0;
                if (out_valid && !out_ready) begin
                    held = 1'b1;
                    held_word = {out_last, out_data};
                end
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected word", {out_last, out_data}, '0);
                    end else begin
                        logic [64:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({out_last, out_data} == e, t, {out_last, out_data}, e);
                    end
                end
            end
        end
    end

    always @(negedge clk) if (rst_n && frame_drop) drops_seen++;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R12 watchdog: actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R11 reset out_valid", 65'(out_valid), 65'd0);
        check(in_ready == 1'b1, "R12 reset in_ready", 65'(in_ready), 65'd1);
        check(frame_drop == 1'b0, "R2 reset frame_drop", 65'(frame_drop), 65'd0);

        // map of a gradient, followed at once by a sparse list frame
        for (int p = 0; p < NP; p++) pix[p] = 8'(10 + 3*p);
        send_frame(1, 60, 40, 1'b0, 2, "R1 R4 R5 R6 R8", 1'b0);
        for (int p = 0; p < NP; p++) pix[p] = 8'd20;
        pix[0] = 8'd200; pix[9] = 8'd200; pix[27] = 8'd180; pix[63] = 8'd220; pix[7] = 8'd90;
        stall_cnt = 0;
        send_frame(0, 30, 50, 1'b0, 3, "R6 R7", 1'b0);
        check(stall_cnt <= 1, "R12 capture during processing", 65'(stall_cnt), 65'd1);

        for (int p = 0; p < NP; p++) pix[p] = 8'($urandom);
        send_frame(2, 25, 100, 1'b0, 1, "R9", 1'b0);
        for (int p = 0; p < NP; p++) pix[p] = 8'($urandom);
        send_frame(3, 0, 255, 1'b0, 0, "R10", 1'b0);

        send_bad(10);
        send_bad(70);
        // stray samples without a frame start
        drive_sample(8'd255, 1'b0, 1'b0);
        drive_sample(8'd255, 1'b0, 1'b1);
        drive_sample(8'd1,   1'b0, 1'b0);

        for (int p = 0; p < NP; p++) pix[p] = 8'd250;
        send_frame(1, 200, 100, 1'b0, 7, "R1 R4 no qualifying sample", 1'b0);
        for (int p = 0; p < NP; p++) pix[p] = 8'(10 + 3*p);
        send_frame(0, 50, 200, 1'b1, 2, "R4 bypass", 1'b0);
        for (int p = 0; p < NP; p++) pix[p] = 8'(($urandom % 128) + (p % 3) * 40);
        send_frame(0, 40, 60, 1'b0, 2, "R3 config snapshot", 1'b1);
        for (int p = 0; p < NP; p++) pix[p] = 8'd5;
        send_frame(0, 200, 3, 1'b0, 0, "R7 no hits", 1'b0);

        for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R7 all results delivered", 65'(exp_q.size()), 65'd0);
        check(drops_seen == drops_exp, "R2 drop count", 65'(drops_seen), 65'(drops_exp));
        report();
    end

endmodule